// File: doc/BRIEF.md
# Set-Associative Translation Cache

This block caches page-walk results for a 32-bit virtual address space with 4 KB pages. It holds both page-directory entries and page-table entries. Each stored entry is tagged with a flag that says which of the two kinds it is. A lookup port takes a 20-bit virtual page number and, in the same cycle, returns a hit flag, the cached 32-bit entry word and its kind. When the hit is on a table entry, the port also returns the finished physical address.

A page walker outside the block installs entries through a fill port that uses a valid/ready handshake. A fill is taken on any rising clock edge where both `fill_valid` and `fill_ready` are high. `fill_ready` is held high at all times except during a flush. While a flush is active, the walker must keep its fill asserted and retry it on a later cycle.

The `flush` input models a task switch. It invalidates every entry except those marked global in their entry word. The cache has 16 sets of 4 ways, 64 entries in all. Replacement is chosen per set.

Top module: `tlb_cache`

## Requirements
- R1: After reset every entry is invalid, every lookup misses and `fill_ready` is high. Reset also clears entries marked global.
- R2: The set index is `vpn[3:0]` and the tag is `vpn[19:4]`. Two pages in the same set with different tags never hit on each other's entry.
- R3: On a hit, `lookup_entry` and `lookup_dir` return the word and kind stored by the last fill of that page. On a miss, both outputs are zero.
- R4: At most one way of a set matches a lookup. A fill of a page that is already cached overwrites that way in place.
- R5: `fill_ready` is low exactly while `flush` is high, and a fill offered then is dropped. An accepted fill is visible to lookups from the cycle after its clock edge.
- R6: A fill of a new page into a set that has a free way takes the lowest-numbered free way.
- R7: A fill of a new page into a full set replaces ways in round-robin order. Each set has its own pointer, which starts at way 0 and advances only on such a replacement.
- R8: A flush leaves valid only those entries whose entry word has bit 8 (the global bit) set. Bit 7 (the size bit) and all other bits are stored but have no effect.
- R9: When a lookup and a fill hit the same set in one cycle, the lookup sees the contents from before the fill.
- R10: `lookup_pa_valid` is high only on a hit on a table entry (kind 0). In that case `lookup_pa` equals entry bits 31:12 followed by `lookup_offset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_vpn | input | 20 | Virtual page number to look up |
| lookup_offset | input | 12 | Byte offset within the page |
| lookup_hit | output | 1 | Lookup matched a valid entry |
| lookup_dir | output | 1 | Matched entry is a directory entry (1) or table entry (0) |
| lookup_entry | output | 32 | Matched entry word, zero on a miss |
| lookup_pa_valid | output | 1 | Physical address is valid |
| lookup_pa | output | 32 | Physical address built from a table entry |
| fill_valid | input | 1 | Walker offers an entry |
| fill_ready | output | 1 | Cache can accept a fill this cycle |
| fill_vpn | input | 20 | Page number of the offered entry |
| fill_dir | input | 1 | Offered entry is a directory entry |
| fill_entry | input | 32 | Offered entry word |
| flush | input | 1 | Task-switch flush of non-global entries |

## Verification
The assertions assume that the walker keeps its fill asserted across a flush rather than relying on the fill being taken. They also assume that the cache's own fill path is the only thing that populates a set. This is why they can require one matching way per set at all times. The stimulus obeys both assumptions: every entry arrives through the handshake, and flush and fill overlap only in the directed case that checks the dropped fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_BITS    = 20;
  localparam int OFFSET_BITS = 12;
  localparam int WORD_BITS   = 32;
  localparam int GLOBAL_POS  = 8;
  localparam int SIZE_POS    = 7;

  typedef enum logic [1:0] {
    PICK_MATCH = 2'd0,
    PICK_FREE  = 2'd1,
    PICK_ROUND = 2'd2
  } pick_e;
endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           probe_tag,
  output logic [WAYS-1:0]            way_hit
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = way_valid[w] && (way_tag[w] == probe_tag);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_fire,
  input  logic [IDX_W-1:0] fill_set,
  input  logic [WAYS-1:0]  set_valid,
  input  logic [WAYS-1:0]  set_match,
  output logic [WAY_W-1:0] way_sel
);
  logic [SETS-1:0][WAY_W-1:0] rr_ptr;
  logic [WAY_W-1:0] match_idx, free_idx, cur_ptr;
  pick_e            pick;

  assign cur_ptr = rr_ptr[fill_set];

  always_comb begin
    match_idx = '0;
    free_idx  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (set_match[w])  match_idx = WAY_W'(w);
      if (!set_valid[w]) free_idx  = WAY_W'(w);
    end
    if (|set_match)       pick = PICK_MATCH;
    else if (!(&set_valid)) pick = PICK_FREE;
    else                  pick = PICK_ROUND;
    case (pick)
      PICK_MATCH: way_sel = match_idx;
      PICK_FREE:  way_sel = free_idx;
      default:    way_sel = cur_ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (fill_fire && pick == PICK_ROUND) begin
      rr_ptr[fill_set] <= (cur_ptr == WAY_W'(WAYS - 1)) ? '0 : cur_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int TAG_W      = 16,
  parameter int WORD_W     = 32,
  parameter int GLOBAL_BIT = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [IDX_W-1:0]                       wr_set,
  input  logic [WAY_W-1:0]                       wr_way,
  input  logic [TAG_W-1:0]                       wr_tag,
  input  logic                                   wr_dir,
  input  logic [WORD_W-1:0]                      wr_word,
  input  logic                                   flush,
  output logic [SETS-1:0][WAYS-1:0]              valid_q,
  output logic [SETS-1:0][WAYS-1:0]              dir_q,
  output logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag_q,
  output logic [SETS-1:0][WAYS-1:0][WORD_W-1:0]  word_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= valid_q[s][w] & word_q[s][w][GLOBAL_BIT];
        end
      end
    end else if (wr_en) begin
      valid_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way]  <= wr_tag;
      dir_q[wr_set][wr_way]  <= wr_dir;
      word_q[wr_set][wr_way] <= wr_word;
    end
  end
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
  import tlb_pkg::*;
#(
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int VPN_W      = VPN_BITS,
  parameter int OFF_W      = OFFSET_BITS,
  parameter int WORD_W     = WORD_BITS,
  parameter int GLOBAL_BIT = GLOBAL_POS,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int WAY_W = $clog2(WAYS),
  localparam int PFN_W = WORD_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lookup_vpn,
  input  logic [OFF_W-1:0]  lookup_offset,
  output logic              lookup_hit,
  output logic              lookup_dir,
  output logic [WORD_W-1:0] lookup_entry,
  output logic              lookup_pa_valid,
  output logic [WORD_W-1:0] lookup_pa,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic              fill_dir,
  input  logic [WORD_W-1:0] fill_entry,
  input  logic              flush
);
  logic [SETS-1:0][WAYS-1:0]             valid_q, dir_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0][WORD_W-1:0] word_q;

  logic [IDX_W-1:0] rd_set, wr_set;
  logic [TAG_W-1:0] rd_tag, wr_tag;
  logic [WAYS-1:0]  rd_hit_vec, wr_hit_vec;
  logic [WAY_W-1:0] wr_way;
  logic             fill_fire;
  logic [WORD_W-1:0] rd_word;
  logic             rd_dir;

  assign rd_set = lookup_vpn[IDX_W-1:0];
  assign rd_tag = lookup_vpn[VPN_W-1:IDX_W];
  assign wr_set = fill_vpn[IDX_W-1:0];
  assign wr_tag = fill_vpn[VPN_W-1:IDX_W];

  assign fill_ready = !flush;
  assign fill_fire  = fill_valid && fill_ready;

  tlb_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .WORD_W(WORD_W), .GLOBAL_BIT(GLOBAL_BIT)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fill_fire), .wr_set(wr_set), .wr_way(wr_way), .wr_tag(wr_tag),
    .wr_dir(fill_dir), .wr_word(fill_entry), .flush(flush),
    .valid_q(valid_q), .dir_q(dir_q), .tag_q(tag_q), .word_q(word_q)
  );

  tlb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_rd_match (
    .way_valid(valid_q[rd_set]), .way_tag(tag_q[rd_set]),
    .probe_tag(rd_tag), .way_hit(rd_hit_vec)
  );

  tlb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_wr_match (
    .way_valid(valid_q[wr_set]), .way_tag(tag_q[wr_set]),
    .probe_tag(wr_tag), .way_hit(wr_hit_vec)
  );

  tlb_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk(clk), .rst_n(rst_n), .fill_fire(fill_fire), .fill_set(wr_set),
    .set_valid(valid_q[wr_set]), .set_match(wr_hit_vec), .way_sel(wr_way)
  );

  always_comb begin
    rd_word = '0;
    rd_dir  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (rd_hit_vec[w]) begin
        rd_word = rd_word | word_q[rd_set][w];
        rd_dir  = rd_dir  | dir_q[rd_set][w];
      end
    end
  end

  assign lookup_hit      = |rd_hit_vec;
  assign lookup_entry    = rd_word;
  assign lookup_dir      = rd_dir;
  assign lookup_pa_valid = lookup_hit && !rd_dir;
  assign lookup_pa       = lookup_pa_valid ? {rd_word[WORD_W-1 -: PFN_W], lookup_offset} : '0;
endmodule

// File: rtl/tlb_cache_chk.sv
module tlb_cache_chk #(
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int VPN_W      = 20,
  parameter int WORD_W     = 32,
  parameter int GLOBAL_BIT = 8,
  localparam int IDX_W = $clog2(SETS)
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  flush,
  input logic                                  fill_valid,
  input logic                                  fill_ready,
  input logic [VPN_W-1:0]                      fill_vpn,
  input logic [SETS-1:0][WAYS-1:0]             valid_q,
  input logic [SETS-1:0][WAYS-1:0][WORD_W-1:0] word_q,
  input logic [WAYS-1:0]                       rd_hit_vec,
  input logic                                  lookup_hit,
  input logic                                  lookup_dir,
  input logic [WORD_W-1:0]                     lookup_entry,
  input logic                                  lookup_pa_valid
);
  logic local_any;
  logic fire;

  assign fire = fill_valid && fill_ready;

  always_comb begin
    local_any = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        if (valid_q[s][w] && !word_q[s][w][GLOBAL_BIT]) local_any = 1'b1;
  end

  p_single_way_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_hit_vec));

  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_hit |-> (lookup_entry == '0 && !lookup_dir));

  p_flush_global_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !local_any);

  p_fill_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (valid_q[$past(fill_vpn[IDX_W-1:0])] != '0));

  p_no_flush_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fire);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !flush) |=> $stable(valid_q));

  p_pa_table_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_pa_valid |-> (lookup_hit && !lookup_dir));
endmodule

bind tlb_cache tlb_cache_chk #(
  .SETS(SETS), .WAYS(WAYS), .VPN_W(VPN_W), .WORD_W(WORD_W), .GLOBAL_BIT(GLOBAL_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .fill_valid(fill_valid),
  .fill_ready(fill_ready), .fill_vpn(fill_vpn), .valid_q(valid_q),
  .word_q(word_q), .rd_hit_vec(rd_hit_vec), .lookup_hit(lookup_hit),
  .lookup_dir(lookup_dir), .lookup_entry(lookup_entry),
  .lookup_pa_valid(lookup_pa_valid)
);

// File: tb/tlb_cache_bench.sv
`timescale 1ns/1ps
module tlb_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] lookup_vpn = '0;
  logic [11:0] lookup_offset = '0;
  logic        lookup_hit, lookup_dir, lookup_pa_valid, fill_ready;
  logic [31:0] lookup_entry, lookup_pa;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic        fill_dir = 1'b0;
  logic [31:0] fill_entry = '0;
  logic        flush = 1'b0;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tlb_cache u_tlb_cache (
    .clk(clk), .rst_n(rst_n), .lookup_vpn(lookup_vpn), .lookup_offset(lookup_offset),
    .lookup_hit(lookup_hit), .lookup_dir(lookup_dir), .lookup_entry(lookup_entry),
    .lookup_pa_valid(lookup_pa_valid), .lookup_pa(lookup_pa),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_dir(fill_dir), .fill_entry(fill_entry), .flush(flush)
  );

  typedef struct packed {
    logic [1:0]  op;     // 0 lookup, 1 fill, 2 flush
    logic [19:0] vpn;
    logic        dir;
    logic [31:0] word;
    logic        exp_hit;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 20'h00011, 1'b0, 32'h1234_5000, 1'b0, 4'd3},
    '{2'd0, 20'h00011, 1'b0, 32'h1234_5000, 1'b1, 4'd3},  // R3 hit
    '{2'd0, 20'h00021, 1'b0, 32'h0,         1'b0, 4'd2},  // R2 same set, other tag
    '{2'd1, 20'h00021, 1'b1, 32'hABCD_E100, 1'b0, 4'd3},
    '{2'd0, 20'h00021, 1'b1, 32'hABCD_E100, 1'b1, 4'd3},
    '{2'd1, 20'h00031, 1'b0, 32'h0000_3000, 1'b0, 4'd6},
    '{2'd1, 20'h00041, 1'b0, 32'h0000_4080, 1'b0, 4'd6},
    '{2'd1, 20'h00051, 1'b0, 32'h0000_5000, 1'b0, 4'd7},  // R7 evicts way 0
    '{2'd0, 20'h00011, 1'b0, 32'h0,         1'b0, 4'd7},
    '{2'd0, 20'h00051, 1'b0, 32'h0000_5000, 1'b1, 4'd7},
    '{2'd1, 20'h00061, 1'b0, 32'h0000_6000, 1'b0, 4'd7},  // evicts way 1
    '{2'd0, 20'h00021, 1'b0, 32'h0,         1'b0, 4'd7},
    '{2'd0, 20'h00031, 1'b0, 32'h0000_3000, 1'b1, 4'd7},
    '{2'd1, 20'h00031, 1'b0, 32'h0000_3300, 1'b0, 4'd4},  // R4 in place
    '{2'd0, 20'h00031, 1'b0, 32'h0000_3300, 1'b1, 4'd4},
    '{2'd1, 20'h00071, 1'b0, 32'h0000_7000, 1'b0, 4'd7},  // evicts way 2
    '{2'd0, 20'h00041, 1'b0, 32'h0000_4080, 1'b1, 4'd7},
    '{2'd0, 20'h00031, 1'b0, 32'h0,         1'b0, 4'd7},
    '{2'd1, 20'h00002, 1'b1, 32'h0000_8100, 1'b0, 4'd8},
    '{2'd1, 20'h00012, 1'b0, 32'h0000_9000, 1'b0, 4'd8},
    '{2'd2, 20'h00000, 1'b0, 32'h0,         1'b0, 4'd8},
    '{2'd0, 20'h00002, 1'b1, 32'h0000_8100, 1'b1, 4'd8},  // R8 global kept
    '{2'd0, 20'h00012, 1'b0, 32'h0,         1'b0, 4'd8},
    '{2'd0, 20'h00041, 1'b0, 32'h0,         1'b0, 4'd8},  // size bit alone no effect
    '{2'd1, 20'h00005, 1'b0, 32'h000A_0000, 1'b0, 4'd6},
    '{2'd1, 20'h00015, 1'b0, 32'h000B_0100, 1'b0, 4'd6},
    '{2'd1, 20'h00025, 1'b0, 32'h000C_0000, 1'b0, 4'd6},
    '{2'd1, 20'h00035, 1'b0, 32'h000D_0000, 1'b0, 4'd6},
    '{2'd2, 20'h00000, 1'b0, 32'h0,         1'b0, 4'd8},
    '{2'd1, 20'h00045, 1'b0, 32'h000E_0000, 1'b0, 4'd6},  // R6 way 0
    '{2'd1, 20'h00055, 1'b0, 32'h000F_0000, 1'b0, 4'd6},  // way 2
    '{2'd1, 20'h00065, 1'b0, 32'h0010_0000, 1'b0, 4'd6},  // way 3
    '{2'd1, 20'h00075, 1'b0, 32'h0011_0000, 1'b0, 4'd6},  // round robin way 0
    '{2'd0, 20'h00045, 1'b0, 32'h0,         1'b0, 4'd6},
    '{2'd0, 20'h00015, 1'b0, 32'h000B_0100, 1'b1, 4'd6},
    '{2'd0, 20'h00065, 1'b0, 32'h0010_0000, 1'b1, 4'd6},
    '{2'd0, 20'h00075, 1'b0, 32'h0011_0000, 1'b1, 4'd6}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [19:0] v, input logic d, input logic [31:0] w);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = v; fill_dir = d; fill_entry = w;
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
  endtask

  task automatic do_look(input logic [19:0] v, input logic eh, input logic ed,
                         input logic [31:0] ew, input int r);
    string tag;
    @(negedge clk);
    lookup_vpn = v;
    #2;
    tag = $sformatf("R%0d vpn=%h", r, v);
    check(tag, {63'd0, lookup_hit}, {63'd0, eh});
    check(tag, {31'd0, lookup_dir, lookup_entry}, eh ? {31'd0, ed, ew} : 64'd0);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    do_look(20'h00011, 1'b0, 1'b0, 32'h0, 1);
    check("R1 fill_ready after reset", {63'd0, fill_ready}, 64'd1);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd1: do_fill(VEC[i].vpn, VEC[i].dir, VEC[i].word);
        2'd2: do_flush();
        default: do_look(VEC[i].vpn, VEC[i].exp_hit, VEC[i].dir, VEC[i].word, int'(VEC[i].req));
      endcase
    end

    // R10 physical address on a table-entry hit
    do_fill(20'h12345, 1'b0, 32'h8765_4000);
    @(negedge clk);
    lookup_vpn = 20'h12345; lookup_offset = 12'hABC;
    #2;
    check("R10 pa_valid", {63'd0, lookup_pa_valid}, 64'd1);
    check("R10 pa", {32'd0, lookup_pa}, {32'd0, 32'h8765_4ABC});
    do_fill(20'h00018, 1'b1, 32'h0004_2000);
    @(negedge clk);
    lookup_vpn = 20'h00018;
    #2;
    check("R10 dir hit no pa", {62'd0, lookup_hit, lookup_pa_valid}, {62'd0, 2'b10});

    // R9 lookup and fill of the same page in one cycle
    @(negedge clk);
    lookup_vpn = 20'h0ABC3;
    fill_valid = 1'b1; fill_vpn = 20'h0ABC3; fill_dir = 1'b0; fill_entry = 32'h0055_5000;
    #2;
    check("R9 pre-fill view", {63'd0, lookup_hit}, 64'd0);
    @(posedge clk); #1;
    fill_valid = 1'b0;
    #1;
    check("R9 after edge", {32'd0, lookup_entry}, {32'd0, 32'h0055_5000});

    // R5 fill offered during flush is dropped
    @(negedge clk);
    flush = 1'b1;
    fill_valid = 1'b1; fill_vpn = 20'h0777E; fill_dir = 1'b0; fill_entry = 32'h0066_6100;
    #2;
    check("R5 ready low in flush", {63'd0, fill_ready}, 64'd0);
    @(posedge clk); #1;
    flush = 1'b0; fill_valid = 1'b0;
    do_look(20'h0777E, 1'b0, 1'b0, 32'h0, 5);

    // R1 reset clears global entries too
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    do_look(20'h00002, 1'b0, 1'b0, 32'h0, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule